// File: doc/BRIEF.md
# Indirect-Access Channel Configuration Register File

This block keeps the configuration of a two-channel disk interface controller in one small register file. Software does not address the registers directly. It first loads an 8-bit pointer register. The pointer names a channel and a register index, and it carries a few global timing and bus options. Software then reads or writes a 16-bit data port, and the access reaches the register that the pointer names. When auto-increment is on, the index steps after each data-port access. This lets a block of registers be loaded or dumped with back-to-back data accesses.

Each channel has its own command block base, general config byte, 10-bit read-ahead count with its enables, control block base, and two timing bytes. Every stored field drives an output port, so that the transfer logic can use it. Some registers and bits can be written but not read: they are stored and drive outputs, but a read returns zero in their place. There is no state machine in the block. The only sequencing is the pointer update, which takes one of three cases in each cycle: load, step, or hold.

- **Load:** the pointer is written.
- **Step:** there is a data access with auto-increment on.
- **Hold:** anything else.

The data port read value is combinational. It always shows the register that the pointer currently selects. `dat_rd` matters only as an access that can step the pointer.

Top module: `idx_cfg_regfile`

## Requirements
- R1: After reset the pointer reads 0x50. Both channels reset as follows: general config 0x01, timing bytes 0xF5 (data) and 0xDE (command), read-ahead state 0. The command base is 0x01F0 on channel 0 and 0x0170 on channel 1. The control base is 0x03F6 on channel 0 and 0x0376 on channel 1.
- R2: Pointer bit 3 selects the channel (0 or 1) and pointer bits 2-0 select the index. A data-port write updates only that register, and the new value appears on the outputs one cycle later.
- R3: With pointer bit 7 set, each data-port read or write advances the pointer index by one. The index wraps from 7 to 0, and the channel bit never changes.
- R4: With pointer bit 7 clear, data-port accesses leave the pointer unchanged.
- R5: Pointer bit 6 drives `cfg_posted_ws`, bit 5 drives `cfg_burst_off` and bit 4 drives `cfg_sel_medium`. Bit 5 always reads back as 0.
- R6: Index 0 (command base) and index 4 (control base) store and read back all 16 bits.
- R7: Indices 1, 5 and 6 store the low data byte, ignore the high byte, and read back with the high byte 0.
- R8: Index 1 bit 2 (power save) is stored and appears on `gen_cfg`, but reads back as 0.
- R9: Index 2 loads count bits 7-0 and index 3 loads count bits 9-8 from its bits 1-0. Index 3 also loads the read-ahead enable from bit 7 and the mode-4 timing enable from bit 4. Both indices read back as 0.
- R10: Writing index 3 with bit 6 set makes `fifo_clear` of that channel high for exactly the next cycle. The bit is not stored.
- R11: Index 7 reads as 0, and writes to it change no register.
- R12: When a pointer write and a data access happen in the same cycle, the data access uses the old pointer and the pointer takes the written value without stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 8 | Pointer write value |
| ptr_rdata | output | 8 | Pointer readback (bit 5 forced 0) |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe (steps the pointer) |
| dat_wdata | input | 16 | Data-port write value |
| dat_rdata | output | 16 | Readback of the selected register |
| cfg_autoinc | output | 1 | Auto-increment enabled |
| cfg_posted_ws | output | 1 | Posted write with at least one wait state |
| cfg_burst_off | output | 1 | Master burst disabled |
| cfg_sel_medium | output | 1 | Medium select timing |
| cmd_base | output | 2x16 | Command block base per channel |
| gen_cfg | output | 2x8 | General config byte per channel |
| ra_count | output | 2x10 | Read-ahead count per channel |
| ra_enable | output | 2 | Read-ahead enable per channel |
| ra_mode4 | output | 2 | Mode-4 timing enable per channel |
| fifo_clear | output | 2 | One-cycle FIFO clear pulse per channel |
| ctl_base | output | 2x16 | Control block base per channel |
| tim_data | output | 2x8 | Data-port timing byte per channel |
| tim_cmd | output | 2x8 | Command/control timing byte per channel |

## Verification
The assertions watch the following on every cycle:
- the pointer's three update cases;
- the zero readback of write-only indices, index 7 and the hidden bits;
- the cause of every FIFO clear pulse;
- the fact that index 7 writes leave every register unchanged.

Only the bench scenarios can show the rest:
- the reset values;
- that a write lands in the right channel and leaves the other one alone;
- that the 10-bit count is assembled from two separate writes;
- the wrap of the index from 7 to 0 within a long auto-increment burst.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int RA_W   = 10;
    localparam int NUM_CH = 2;
    localparam int IDX_W  = 3;

    // register index codes selected by pointer bits 2-0
    typedef enum logic [IDX_W-1:0] {
        IDX_CMD_BASE = 3'd0,
        IDX_GEN      = 3'd1,
        IDX_RA_LO    = 3'd2,
        IDX_RA_CTL   = 3'd3,
        IDX_CTL_BASE = 3'd4,
        IDX_TIM_DATA = 3'd5,
        IDX_TIM_CMD  = 3'd6,
        IDX_NONE     = 3'd7
    } cfg_idx_e;

    // general config bits that are stored but hidden on readback
    localparam logic [BYTE_W-1:0] GEN_HIDDEN = 8'h04;
    // pointer bits hidden on readback
    localparam logic [BYTE_W-1:0] PTR_HIDDEN = 8'h20;
    localparam logic [BYTE_W-1:0] PTR_RESET  = 8'h50;
    localparam logic [BYTE_W-1:0] GEN_RESET  = 8'h01;
endpackage

// File: rtl/cfg_ptr.sv
module cfg_ptr
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [BYTE_W-1:0] ptr_wdata,
    input  logic              access,
    output logic [BYTE_W-1:0] ptr_q,
    output logic              ptr_ch,
    output cfg_idx_e          ptr_idx
);
    logic [BYTE_W-1:0] ptr_next;

    // load wins over step; step only touches the index field
    always_comb begin
        ptr_next = ptr_q;
        if (ptr_wr) begin
            ptr_next = ptr_wdata;
        end else if (access && ptr_q[7]) begin
            ptr_next[IDX_W-1:0] = ptr_q[IDX_W-1:0] + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= PTR_RESET;
        else        ptr_q <= ptr_next;
    end

    assign ptr_ch  = ptr_q[3];
    assign ptr_idx = cfg_idx_e'(ptr_q[IDX_W-1:0]);

    a_r3_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ptr_wr && ptr_q[7]) |=>
            (ptr_q[IDX_W-1:0] == $past(ptr_q[IDX_W-1:0]) + 3'd1));
    a_r3_channel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ptr_wr) |=> (ptr_q[BYTE_W-1:IDX_W] == $past(ptr_q[BYTE_W-1:IDX_W])));
    a_r4_pointer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_wr && !(access && ptr_q[7])) |=> $stable(ptr_q));
    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (ptr_q == $past(ptr_wdata)));
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_CMD = 16'h01F0,
    parameter logic [DATA_W-1:0] RST_CTL = 16'h03F6,
    parameter logic [BYTE_W-1:0] RST_TD  = 8'hF5,
    parameter logic [BYTE_W-1:0] RST_TC  = 8'hDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cfg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cmd_base,
    output logic [BYTE_W-1:0] gen_cfg,
    output logic [RA_W-1:0]   ra_count,
    output logic              ra_enable,
    output logic              ra_mode4,
    output logic              fifo_clear,
    output logic [DATA_W-1:0] ctl_base,
    output logic [BYTE_W-1:0] tim_data,
    output logic [BYTE_W-1:0] tim_cmd
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_base   <= RST_CMD;
            gen_cfg    <= GEN_RESET;
            ra_count   <= '0;
            ra_enable  <= 1'b0;
            ra_mode4   <= 1'b0;
            fifo_clear <= 1'b0;
            ctl_base   <= RST_CTL;
            tim_data   <= RST_TD;
            tim_cmd    <= RST_TC;
        end else begin
            fifo_clear <= 1'b0;
            if (wr_en) begin
                unique case (idx)
                    IDX_CMD_BASE: cmd_base <= wdata;
                    IDX_GEN:      gen_cfg  <= wdata[BYTE_W-1:0];
                    IDX_RA_LO:    ra_count[BYTE_W-1:0] <= wdata[BYTE_W-1:0];
                    IDX_RA_CTL: begin
                        ra_count[RA_W-1:BYTE_W] <= wdata[RA_W-BYTE_W-1:0];
                        ra_enable  <= wdata[7];
                        ra_mode4   <= wdata[4];
                        fifo_clear <= wdata[6];
                    end
                    IDX_CTL_BASE: ctl_base <= wdata;
                    IDX_TIM_DATA: tim_data <= wdata[BYTE_W-1:0];
                    IDX_TIM_CMD:  tim_cmd  <= wdata[BYTE_W-1:0];
                    IDX_NONE: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (idx)
            IDX_CMD_BASE: rdata = cmd_base;
            IDX_GEN:      rdata = {8'h00, gen_cfg & ~GEN_HIDDEN};
            IDX_CTL_BASE: rdata = ctl_base;
            IDX_TIM_DATA: rdata = {8'h00, tim_data};
            IDX_TIM_CMD:  rdata = {8'h00, tim_cmd};
            IDX_RA_LO, IDX_RA_CTL, IDX_NONE: rdata = '0;
        endcase
    end

    a_r10_clear_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |-> $past(wr_en && idx == IDX_RA_CTL && wdata[6]));
    a_r7_byte_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_GEN || idx == IDX_TIM_DATA || idx == IDX_TIM_CMD) |-> (rdata[15:8] == 8'h00));
endmodule

// File: rtl/idx_cfg_regfile.sv
module idx_cfg_regfile
    import cfg_pkg::*;
#(
    parameter logic [15:0] PRI_CMD_BASE = 16'h01F0,
    parameter logic [15:0] SEC_CMD_BASE = 16'h0170,
    parameter logic [15:0] PRI_CTL_BASE = 16'h03F6,
    parameter logic [15:0] SEC_CTL_BASE = 16'h0376,
    parameter logic [7:0]  TIM_DATA_RST = 8'hF5,
    parameter logic [7:0]  TIM_CMD_RST  = 8'hDE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_wr,
    input  logic [7:0]       ptr_wdata,
    output logic [7:0]       ptr_rdata,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [15:0]      dat_wdata,
    output logic [15:0]      dat_rdata,
    output logic             cfg_autoinc,
    output logic             cfg_posted_ws,
    output logic             cfg_burst_off,
    output logic             cfg_sel_medium,
    output logic [1:0][15:0] cmd_base,
    output logic [1:0][7:0]  gen_cfg,
    output logic [1:0][9:0]  ra_count,
    output logic [1:0]       ra_enable,
    output logic [1:0]       ra_mode4,
    output logic [1:0]       fifo_clear,
    output logic [1:0][15:0] ctl_base,
    output logic [1:0][7:0]  tim_data,
    output logic [1:0][7:0]  tim_cmd
);
    logic [BYTE_W-1:0]             ptr_q;
    logic                          ptr_ch;
    cfg_idx_e                      ptr_idx;
    logic [NUM_CH-1:0][DATA_W-1:0] bank_rdata;

    cfg_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_wr   (ptr_wr),
        .ptr_wdata(ptr_wdata),
        .access   (dat_wr | dat_rd),
        .ptr_q    (ptr_q),
        .ptr_ch   (ptr_ch),
        .ptr_idx  (ptr_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cfg_bank #(
            .RST_CMD(c == 0 ? PRI_CMD_BASE : SEC_CMD_BASE),
            .RST_CTL(c == 0 ? PRI_CTL_BASE : SEC_CTL_BASE),
            .RST_TD (TIM_DATA_RST),
            .RST_TC (TIM_CMD_RST)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (dat_wr && (ptr_ch == c[0])),
            .idx       (ptr_idx),
            .wdata     (dat_wdata),
            .rdata     (bank_rdata[c]),
            .cmd_base  (cmd_base[c]),
            .gen_cfg   (gen_cfg[c]),
            .ra_count  (ra_count[c]),
            .ra_enable (ra_enable[c]),
            .ra_mode4  (ra_mode4[c]),
            .fifo_clear(fifo_clear[c]),
            .ctl_base  (ctl_base[c]),
            .tim_data  (tim_data[c]),
            .tim_cmd   (tim_cmd[c])
        );
    end

    assign dat_rdata      = bank_rdata[ptr_ch];
    assign ptr_rdata      = ptr_q & ~PTR_HIDDEN;
    assign cfg_autoinc    = ptr_q[7];
    assign cfg_posted_ws  = ptr_q[6];
    assign cfg_burst_off  = ptr_q[5];
    assign cfg_sel_medium = ptr_q[4];

    a_r5_burst_bit_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (ptr_rdata[5] == 1'b0 && cfg_burst_off == $past(ptr_wdata[5])));
    a_r9_wo_index_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_idx == IDX_RA_LO || ptr_idx == IDX_RA_CTL) |-> (dat_rdata == 16'h0000));
    a_r8_power_bit_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_idx == IDX_GEN) |-> (dat_rdata[2] == 1'b0));
    a_r11_idx7_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_idx == IDX_NONE) |-> (dat_rdata == 16'h0000));
    a_r11_idx7_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && ptr_idx == IDX_NONE) |=>
            ($stable(cmd_base) && $stable(gen_cfg) && $stable(ra_count) && $stable(ctl_base)
             && $stable(tim_data) && $stable(tim_cmd) && $stable(ra_enable) && $stable(ra_mode4)));
endmodule

// File: tb/idx_cfg_regfile_tb_top.sv
`timescale 1ns/1ps
module idx_cfg_regfile_tb_top;
    logic             clk = 1'b0;
    logic             rst_n;
    logic             ptr_wr;
    logic [7:0]       ptr_wdata;
    logic [7:0]       ptr_rdata;
    logic             dat_wr;
    logic             dat_rd;
    logic [15:0]      dat_wdata;
    logic [15:0]      dat_rdata;
    logic             cfg_autoinc, cfg_posted_ws, cfg_burst_off, cfg_sel_medium;
    logic [1:0][15:0] cmd_base;
    logic [1:0][7:0]  gen_cfg;
    logic [1:0][9:0]  ra_count;
    logic [1:0]       ra_enable, ra_mode4, fifo_clear;
    logic [1:0][15:0] ctl_base;
    logic [1:0][7:0]  tim_data, tim_cmd;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [15:0] exp_q[$];
    string       req_q[$];

    always #2 clk = ~clk;

    idx_cfg_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .cfg_autoinc(cfg_autoinc), .cfg_posted_ws(cfg_posted_ws), .cfg_burst_off(cfg_burst_off),
        .cfg_sel_medium(cfg_sel_medium), .cmd_base(cmd_base), .gen_cfg(gen_cfg),
        .ra_count(ra_count), .ra_enable(ra_enable), .ra_mode4(ra_mode4), .fifo_clear(fifo_clear),
        .ctl_base(ctl_base), .tim_data(tim_data), .tim_cmd(tim_cmd)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ptr_wr = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0;
    endtask

    task automatic wptr(input logic [7:0] v);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = v; dat_wr = 1'b0; dat_rd = 1'b0;
    endtask

    task automatic wdat(input logic [15:0] v);
        @(negedge clk);
        ptr_wr = 1'b0; dat_wr = 1'b1; dat_wdata = v; dat_rd = 1'b0;
    endtask

    // driver: issue a read and push the expected word to the scoreboard
    task automatic rdat(input logic [15:0] exp, input string req);
        @(negedge clk);
        ptr_wr = 1'b0; dat_wr = 1'b0; dat_rd = 1'b1;
        exp_q.push_back(exp);
        req_q.push_back(req);
    endtask

    // monitor: compare each read as it is presented
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (dat_rd === 1'b1) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL scoreboard: unexpected read 0x%04h expected none", dat_rdata);
                end else begin
                    chk(dat_rdata, exp_q.pop_front(), req_q.pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; ptr_wr = 1'b0; ptr_wdata = '0; dat_wr = 1'b0; dat_rd = 1'b0; dat_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk({8'h0, ptr_rdata}, 16'h0050, "R1 pointer");
        chk(cmd_base[0], 16'h01F0, "R1 cmd0");
        chk(cmd_base[1], 16'h0170, "R1 cmd1");
        chk(ctl_base[0], 16'h03F6, "R1 ctl0");
        chk(ctl_base[1], 16'h0376, "R1 ctl1");
        chk({tim_data[1], tim_cmd[1]}, 16'hF5DE, "R1 timing1");
        chk({gen_cfg[0], gen_cfg[1]}, 16'h0101, "R1 gen");
        chk({6'h0, ra_count[0]}, 16'h0000, "R1 ra0");
        // R3 auto-increment burst read of channel 0 with wrap
        wptr(8'h80);
        rdat(16'h01F0, "R3 idx0");
        rdat(16'h0001, "R3 idx1");
        rdat(16'h0000, "R9 idx2 read");
        rdat(16'h0000, "R9 idx3 read");
        rdat(16'h03F6, "R3 idx4");
        rdat(16'h00F5, "R3 idx5");
        rdat(16'h00DE, "R3 idx6");
        rdat(16'h0000, "R11 idx7 read");
        rdat(16'h01F0, "R3 wrap to idx0");
        idle();
        chk({8'h0, ptr_rdata}, 16'h0081, "R3 pointer after burst");
        // R2/R6/R7/R8/R9 burst write of channel 1
        wptr(8'h88);
        wdat(16'h1234);
        wdat(16'hFF87);
        wdat(16'h55AA);
        wdat(16'h00D3);
        idle();
        chk({14'h0, fifo_clear}, 16'h0002, "R10 pulse ch1");
        idle();
        chk({14'h0, fifo_clear}, 16'h0000, "R10 pulse ends");
        wdat(16'hBEEF);
        wdat(16'h1109);
        wdat(16'h22C3);
        wdat(16'hFFFF);
        idle();
        chk(cmd_base[1], 16'h1234, "R6 cmd1");
        chk(cmd_base[0], 16'h01F0, "R2 ch0 untouched");
        chk({8'h0, gen_cfg[1]}, 16'h0087, "R8 gen1 stored");
        chk({6'h0, ra_count[1]}, 16'h03AA, "R9 count");
        chk({14'h0, ra_enable[1], ra_mode4[1]}, 16'h0003, "R9 enables");
        chk(ctl_base[1], 16'hBEEF, "R6 ctl1");
        chk({tim_data[1], tim_cmd[1]}, 16'h09C3, "R7 timing1");
        chk({8'h0, ptr_rdata}, 16'h0088, "R11 write idx7 wrap");
        rdat(16'h1234, "R6 read cmd1");
        rdat(16'h0083, "R8 gen hidden bit");
        rdat(16'h0000, "R9 idx2 wo");
        rdat(16'h0000, "R9 idx3 wo");
        rdat(16'hBEEF, "R6 read ctl1");
        rdat(16'h0009, "R7 tim data");
        rdat(16'h00C3, "R7 tim cmd");
        rdat(16'h0000, "R11 idx7");
        idle();
        chk({tim_data[1], tim_cmd[1]}, 16'h09C3, "R11 idx7 write ignored");
        // R4/R5 no auto-increment, pointer option bits
        wptr(8'h51);
        idle();
        chk({12'h0, cfg_autoinc, cfg_posted_ws, cfg_burst_off, cfg_sel_medium}, 16'h0005, "R5 options");
        wptr(8'h71);
        idle();
        chk({8'h0, ptr_rdata}, 16'h0051, "R5 bit5 hidden");
        chk({15'h0, cfg_burst_off}, 16'h0001, "R5 burst off");
        rdat(16'h0001, "R4 read 1");
        rdat(16'h0001, "R4 read 2");
        wdat(16'h0000);
        idle();
        chk({8'h0, ptr_rdata}, 16'h0051, "R4 pointer held");
        chk({8'h0, gen_cfg[0]}, 16'h0000, "R4 gen0 written");
        // R12 simultaneous pointer load and data write
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = 8'h80; dat_wr = 1'b1; dat_wdata = 16'h0021; dat_rd = 1'b0;
        idle();
        chk({8'h0, gen_cfg[0]}, 16'h0021, "R12 old pointer used");
        chk({8'h0, ptr_rdata}, 16'h0080, "R12 pointer loaded no step");
        // R10 pulse on channel 0 only, not stored
        wptr(8'h03);
        wdat(16'h0040);
        idle();
        chk({14'h0, fifo_clear}, 16'h0001, "R10 pulse ch0");
        chk({14'h0, ra_enable}, 16'h0002, "R10 enable ch0 clear");
        idle();
        chk({14'h0, fifo_clear}, 16'h0000, "R10 pulse ch0 ends");
        rdat(16'h0000, "R10 idx3 reads zero");
        idle();
        idle();
        done = 1'b1;
        summary();
    end
endmodule